// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair with Edge-Aligned PWM

This block holds the per-channel logic of a 16-bit timer. It has two identical channels. A shared free-running counter is outside the block and reaches it as a count value and a one-cycle wrap pulse. Each channel either captures or compares. In capture mode it samples its input pin and stores the count when a chosen edge arrives. In compare mode it watches for the count to equal its stored value and drives its output pin. Setting the toggle-on-wrap control turns compare mode into edge-aligned PWM: the pin goes active at every wrap and returns inactive on the match.

Software reaches each channel over an 8-bit register bus. Each channel has a control byte and a 16-bit value that is split into a high byte and a low byte. The split access carries interlocks so that a 16-bit transfer stays coherent. In capture mode, reading the high byte holds off new captures until the low byte is read. In compare mode, writing the high byte holds off matches until the low byte is written. A full-duty control pins the PWM output at its active level. The change is applied only at the next counter wrap, so a period is never cut short.

Top module: `tcc_timer`

## Requirements
- R1: A synchronous active-high reset drives both pins to 0. It also clears every control byte, including the event flag, so a control read after reset returns 0x00.
- R2: Control byte fields: bits 1:0 are the mode, bits 3:2 select the edge, bit 4 reads 0, bit 5 is toggle-on-wrap, bit 6 is full duty and bit 7 is the event flag. When mode is 00 and a selected edge is seen, the channel value takes the count present at the second rising clock edge after the input pin changes, and the event flag sets.
- R3: The edge select field takes four values: 00 captures nothing, 01 captures rising edges, 10 captures falling edges and 11 captures both. An edge that is not selected leaves the value and the flag unchanged.
- R4: In mode 00, a high-byte read blocks captures until the low byte is read. An edge that arrives while the block is in force is discarded.
- R5: Channel n sits at byte addresses BASE+4n (control), BASE+4n+1 (value bits 15..8) and BASE+4n+2 (value bits 7..0), with BASE = 0x20. Any other address reads 0x00.
- R6: Modes 01, 10 and 11 compare the count with the value. With toggle-on-wrap off, a match toggles (01), clears (10) or sets (11) the pin one clock edge after the matching cycle, and it sets the event flag.
- R7: In a compare mode, a high-byte write suppresses matches until the low byte is written.
- R8: In a compare mode with toggle-on-wrap on, the pin goes to 1 on the edge after a wrap cycle and to 0 on the edge after a match. If both happen in the same cycle, the wrap wins.
- R9: Full duty holds the PWM pin at 1. A set or clear of the bit takes effect only at the next wrap cycle.
- R10: The event flag clears only on a control write with bit 7 at 0, and only if a control read saw the flag at 1 after the previous control write. A new event in the same cycle keeps the flag set.
- R11: The two channels run independently. Bus traffic and pin activity on one channel leave the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; applies the read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| counter | input | 16 | Shared free-running count |
| cnt_wrap | input | 1 | High during the last count of each period |
| cap_in | input | 2 | Capture input pin per channel |
| pin_out | output | 2 | Compare/PWM output pin per channel |

## Verification
Each result has its own latency, and the bench checks each one at that point. Read data is checked in the same cycle as the address, about a nanosecond after the bench drives it. The read side effects on the locks and on the flag take hold at the clock edge that follows. A captured value reflects the count at the second edge after the pin moves. A pin change shows one edge after its match or wrap cycle. A full-duty change shows only after the next wrap. The bench keeps to these latencies by stepping a behavioural model of both channels at every rising edge from the same inputs the design sees. It compares both pins at every falling edge and compares each read in the cycle it is issued.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'b00,
        MODE_TOGGLE  = 2'b01,
        MODE_CLEAR   = 2'b10,
        MODE_SET     = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'b00,
        REG_HIGH = 2'b01,
        REG_LOW  = 2'b10,
        REG_NONE = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic       flag;
        logic       full_duty;
        logic       wrap_tog;
        logic       rsvd;
        edge_sel_e  edge_sel;
        chan_mode_e mode;
    } chan_ctrl_t;

    function automatic logic is_capture(chan_mode_e m);
        return m == MODE_CAPTURE;
    endfunction

    function automatic logic edge_hit(edge_sel_e s, logic rise, logic fall);
        case (s)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tcc_capture_unit.sv
module tcc_capture_unit
    import tcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_in,
    input  edge_sel_e edge_sel,
    input  logic      arm,
    output logic      cap_fire
);
    logic samp_q;
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= cap_in;
            prev_q <= samp_q;
        end
    end

    always_comb begin
        rise     = samp_q & ~prev_q;
        fall     = ~samp_q & prev_q;
        cap_fire = arm & edge_hit(edge_sel, rise, fall);
    end

endmodule

// File: rtl/tcc_compare_unit.sv
module tcc_compare_unit
    import tcc_pkg::*;
#(
    parameter int CNT_W = tcc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] counter,
    input  logic             cnt_wrap,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             enable,
    input  logic             lock,
    input  chan_mode_e       mode,
    input  logic             wrap_tog,
    input  logic             full_duty,
    output logic             match,
    output logic             pin
);
    logic pin_q;
    logic full_eff_q;
    logic pwm;

    always_comb begin
        match = enable & ~lock & (counter == cmp_val);
        pwm   = enable & wrap_tog;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q      <= 1'b0;
            full_eff_q <= 1'b0;
        end else begin
            if (cnt_wrap) begin
                full_eff_q <= full_duty;
            end
            if (pwm) begin
                if (cnt_wrap) begin
                    pin_q <= 1'b1;
                end else if (match && !full_eff_q) begin
                    pin_q <= 1'b0;
                end
            end else if (match) begin
                case (mode)
                    MODE_TOGGLE: pin_q <= ~pin_q;
                    MODE_CLEAR:  pin_q <= 1'b0;
                    MODE_SET:    pin_q <= 1'b1;
                    default:     pin_q <= pin_q;
                endcase
            end
        end
    end

    assign pin = pin_q;

    // R8: a wrap cycle in PWM operation leaves the pin active
    p_wrap_activates_r8: assert property (@(posedge clk) disable iff (rst)
        (pwm && cnt_wrap) |=> pin_q);

    // R9: once full duty is in force, an active pin stays active
    p_full_duty_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pwm && full_eff_q && pin_q) |=> pin_q);

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int               CNT_W  = tcc_pkg::CNT_W,
    parameter int               ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  counter,
    input  logic              cnt_wrap,
    input  logic              cap_in,
    output logic [BYTE_W-1:0] rdata,
    output logic              pin
);
    localparam int HI_LSB = CNT_W - BYTE_W;

    reg_sel_e         sel;
    chan_ctrl_t       ctrl_q;
    chan_ctrl_t       ctrl_wr;
    logic [CNT_W-1:0] val_q;
    logic             cap_lock_q;
    logic             cmp_lock_q;
    logic             seen_q;
    logic             capture_mode;
    logic             cap_fire;
    logic             match;
    logic             wr_ctrl, wr_high, wr_low;
    logic             rd_ctrl, rd_high, rd_low;
    logic             flag_set, flag_clr;

    always_comb begin
        if (bus_addr == BASE)                        sel = REG_CTRL;
        else if (bus_addr == BASE + ADDR_W'(1))      sel = REG_HIGH;
        else if (bus_addr == BASE + ADDR_W'(2))      sel = REG_LOW;
        else                                         sel = REG_NONE;
    end

    always_comb begin
        capture_mode = is_capture(ctrl_q.mode);
        wr_ctrl  = bus_wr & (sel == REG_CTRL);
        wr_high  = bus_wr & (sel == REG_HIGH);
        wr_low   = bus_wr & (sel == REG_LOW);
        rd_ctrl  = bus_rd & (sel == REG_CTRL);
        rd_high  = bus_rd & (sel == REG_HIGH);
        rd_low   = bus_rd & (sel == REG_LOW);
        flag_set = cap_fire | match;
        flag_clr = wr_ctrl & seen_q & ~bus_wdata[BYTE_W-1];
        ctrl_wr  = chan_ctrl_t'(bus_wdata);
    end

    tcc_capture_unit u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_in   (cap_in),
        .edge_sel (ctrl_q.edge_sel),
        .arm      (capture_mode & ~cap_lock_q),
        .cap_fire (cap_fire)
    );

    tcc_compare_unit #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .counter   (counter),
        .cnt_wrap  (cnt_wrap),
        .cmp_val   (val_q),
        .enable    (~capture_mode),
        .lock      (cmp_lock_q),
        .mode      (ctrl_q.mode),
        .wrap_tog  (ctrl_q.wrap_tog),
        .full_duty (ctrl_q.full_duty),
        .match     (match),
        .pin       (pin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            val_q      <= '0;
            cap_lock_q <= 1'b0;
            cmp_lock_q <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mode      <= ctrl_wr.mode;
                ctrl_q.edge_sel  <= ctrl_wr.edge_sel;
                ctrl_q.wrap_tog  <= ctrl_wr.wrap_tog;
                ctrl_q.full_duty <= ctrl_wr.full_duty;
                ctrl_q.rsvd      <= 1'b0;
            end
            ctrl_q.flag <= flag_set | (ctrl_q.flag & ~flag_clr);

            if (wr_ctrl) begin
                seen_q <= 1'b0;
            end else if (rd_ctrl && ctrl_q.flag) begin
                seen_q <= 1'b1;
            end

            if (cap_fire) begin
                val_q <= counter;
            end
            if (wr_high) begin
                val_q[CNT_W-1:HI_LSB] <= bus_wdata;
            end
            if (wr_low) begin
                val_q[BYTE_W-1:0] <= bus_wdata;
            end

            if (wr_high && !capture_mode) begin
                cmp_lock_q <= 1'b1;
            end else if (wr_low) begin
                cmp_lock_q <= 1'b0;
            end

            if (rd_high && capture_mode) begin
                cap_lock_q <= 1'b1;
            end else if (rd_low) begin
                cap_lock_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL: rdata = ctrl_q;
            REG_HIGH: rdata = val_q[CNT_W-1:HI_LSB];
            REG_LOW:  rdata = val_q[BYTE_W-1:0];
            default:  rdata = '0;
        endcase
    end

    // R2: a capture loads the count seen in the firing cycle
    p_capture_loads_count_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && !wr_high && !wr_low) |=> (val_q == $past(counter)));

    // R4: while the capture block is held, only bus writes move the value
    p_cap_lock_freezes_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_lock_q && !wr_high && !wr_low) |=> $stable(val_q));

    // R7: a held compare block raises no flag
    p_cmp_lock_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_lock_q && !capture_mode && !ctrl_q.flag) |=> !ctrl_q.flag);

    // R10: the flag only falls after it was observed by a control read
    p_flag_clear_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.flag) |-> $past(seen_q));

endmodule

// File: rtl/tcc_timer.sv
module tcc_timer
    import tcc_pkg::*;
#(
    parameter int                NUM_CH    = 2,
    parameter int                CNT_W     = tcc_pkg::CNT_W,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  counter,
    input  logic              cnt_wrap,
    input  logic [NUM_CH-1:0] cap_in,
    output logic [NUM_CH-1:0] pin_out
);
    localparam int CH_STRIDE = 4;

    logic [BYTE_W-1:0] ch_rdata [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tcc_channel #(
            .CNT_W  (CNT_W),
            .ADDR_W (ADDR_W),
            .BASE   (BASE_ADDR + ADDR_W'(i * CH_STRIDE))
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .bus_addr  (bus_addr),
            .bus_wr    (bus_wr),
            .bus_rd    (bus_rd),
            .bus_wdata (bus_wdata),
            .counter   (counter),
            .cnt_wrap  (cnt_wrap),
            .cap_in    (cap_in[i]),
            .rdata     (ch_rdata[i]),
            .pin       (pin_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            bus_rdata = bus_rdata | ch_rdata[i];
        end
    end

endmodule

// File: tb/tcc_timer_bench.sv
`timescale 1ns/1ps
module tcc_timer_bench;
    localparam int NCH  = 2;
    localparam int BASE = 32;
    localparam int MODN = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'hFF;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [15:0] counter = 16'd0;
    logic       cnt_wrap = 1'b0;
    logic [1:0] cap_in = 2'b00;
    logic [1:0] pin_out;

    int total = 0;
    int fails = 0;

    // behavioural model state
    int m_mode[NCH], m_edge[NCH], m_tog[NCH], m_full[NCH], m_flag[NCH], m_seen[NCH];
    int m_val[NCH], m_clk_lock[NCH], m_cmp_lock[NCH], m_h1[NCH], m_h2[NCH];
    int m_feff[NCH], m_pin[NCH];

    always #2.5 clk = ~clk;

    tcc_timer u_tcc_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .counter(counter),
        .cnt_wrap(cnt_wrap), .cap_in(cap_in), .pin_out(pin_out)
    );

    // shared counter, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            counter  = 16'd0;
        end else begin
            counter = (int'(counter) == MODN - 1) ? 16'd0 : counter + 16'd1;
        end
        cnt_wrap = (int'(counter) == MODN - 1);
    end

    function automatic int mread(int a);
        for (int c = 0; c < NCH; c++) begin
            if (a == BASE + 4 * c)
                return (m_flag[c] << 7) | (m_full[c] << 6) | (m_tog[c] << 5) |
                       (m_edge[c] << 2) | m_mode[c];
            if (a == BASE + 4 * c + 1) return (m_val[c] >> 8) & 255;
            if (a == BASE + 4 * c + 2) return m_val[c] & 255;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_mode[c] = 0; m_edge[c] = 0; m_tog[c] = 0; m_full[c] = 0;
                m_flag[c] = 0; m_seen[c] = 0; m_val[c] = 0; m_clk_lock[c] = 0;
                m_cmp_lock[c] = 0; m_h1[c] = 0; m_h2[c] = 0; m_feff[c] = 0; m_pin[c] = 0;
            end else begin
                int  a;
                bit  cap_m, rise, fall, ev, capt, mt, hc, hh, hl;
                a     = int'(bus_addr);
                hc    = (a == BASE + 4 * c);
                hh    = (a == BASE + 4 * c + 1);
                hl    = (a == BASE + 4 * c + 2);
                cap_m = (m_mode[c] == 0);
                rise  = (m_h1[c] == 1) && (m_h2[c] == 0);
                fall  = (m_h1[c] == 0) && (m_h2[c] == 1);
                ev    = (m_edge[c] == 1 && rise) || (m_edge[c] == 2 && fall) ||
                        (m_edge[c] == 3 && (rise || fall));
                capt  = cap_m && ev && (m_clk_lock[c] == 0);
                mt    = !cap_m && (m_cmp_lock[c] == 0) && (int'(counter) == m_val[c]);
                // pin
                if (!cap_m && m_tog[c] == 1) begin
                    if (cnt_wrap) m_pin[c] = 1;
                    else if (mt && m_feff[c] == 0) m_pin[c] = 0;
                end else if (mt) begin
                    if (m_mode[c] == 1) m_pin[c] = 1 - m_pin[c];
                    else if (m_mode[c] == 2) m_pin[c] = 0;
                    else m_pin[c] = 1;
                end
                if (cnt_wrap) m_feff[c] = m_full[c];
                // flag and control
                if (bus_wr && hc) begin
                    if (m_seen[c] == 1 && bus_wdata[7] == 1'b0) m_flag[c] = 0;
                    m_seen[c] = 0;
                    m_mode[c] = bus_wdata[1:0];
                    m_edge[c] = bus_wdata[3:2];
                    m_tog[c]  = bus_wdata[5];
                    m_full[c] = bus_wdata[6];
                end else if (bus_rd && hc && m_flag[c] == 1) begin
                    m_seen[c] = 1;
                end
                if (capt || mt) m_flag[c] = 1;
                // value and locks
                if (capt) m_val[c] = int'(counter);
                if (bus_wr && hh) begin
                    m_val[c] = (m_val[c] & 255) | (int'(bus_wdata) << 8);
                    if (!cap_m) m_cmp_lock[c] = 1;
                end
                if (bus_wr && hl) begin
                    m_val[c] = (m_val[c] & 16'hFF00) | int'(bus_wdata);
                    m_cmp_lock[c] = 0;
                end
                if (bus_rd && hh && cap_m) m_clk_lock[c] = 1;
                else if (bus_rd && hl) m_clk_lock[c] = 0;
                m_h2[c] = m_h1[c];
                m_h1[c] = int'(cap_in[c]);
            end
        end
    end

    // pins compared every cycle against the model
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                string tag;
                tag = (m_mode[c] != 0 && m_tog[c] == 1) ? ((m_feff[c] == 1) ? "R9" : "R8") : "R6";
                total++;
                if (int'(pin_out[c]) != m_pin[c]) begin
                    fails++;
                    $display("FAIL %s pin%0d at t=%0t: actual=%0d expected=%0d",
                             tag, c, $time, pin_out[c], m_pin[c]);
                end
            end
        end
    end

    task automatic bus_write(int a, int d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hFF;
    endtask

    task automatic bus_read(int a, string tag);
        int exp_v;
        @(negedge clk);
        bus_addr = 8'(a); bus_rd = 1'b1;
        #1;
        exp_v = mread(a);
        total++;
        if (int'(bus_rdata) != exp_v) begin
            fails++;
            $display("FAIL %s read 0x%02h: actual=0x%02h expected=0x%02h", tag, a, bus_rdata, exp_v);
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 8'hFF;
    endtask

    task automatic chk_pin(int c, string tag);
        @(negedge clk);
        #1;
        total++;
        if (int'(pin_out[c]) != m_pin[c]) begin
            fails++;
            $display("FAIL %s pin%0d: actual=%0d expected=%0d", tag, c, pin_out[c], m_pin[c]);
        end
    endtask

    task automatic set_cap(int c, bit v);
        @(negedge clk);
        cap_in[c] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam int C0 = BASE, H0 = BASE + 1, L0 = BASE + 2;
    localparam int C1 = BASE + 4, H1 = BASE + 5, L1 = BASE + 6;

    initial begin
        idle(4);
        rst = 1'b0;
        // R1: reset state
        bus_read(C0, "R1");
        bus_read(C1, "R1");
        chk_pin(0, "R1");
        chk_pin(1, "R1");

        // R2: rising-edge capture, flag set
        bus_write(C0, 8'h04);
        idle(7);
        set_cap(0, 1'b1);
        idle(4);
        bus_read(H0, "R2");
        bus_read(L0, "R2");
        bus_read(C0, "R2");
        // R10: clear after read
        bus_write(C0, 8'h04);
        bus_read(C0, "R10");
        // R10: write without prior read keeps the flag
        set_cap(0, 1'b0);
        idle(3);
        set_cap(0, 1'b1);
        idle(4);
        bus_write(C0, 8'h04);
        bus_read(C0, "R10");
        bus_write(C0, 8'h84);
        bus_read(C0, "R10");
        bus_write(C0, 8'h04);
        bus_read(C0, "R10");

        // R3: falling, both, none
        bus_write(C0, 8'h08);
        set_cap(0, 1'b0);
        idle(4);
        bus_read(H0, "R3");
        bus_read(L0, "R3");
        set_cap(0, 1'b1);
        idle(4);
        bus_read(L0, "R3");
        bus_write(C0, 8'h0C);
        set_cap(0, 1'b0);
        idle(5);
        bus_read(L0, "R3");
        set_cap(0, 1'b1);
        idle(6);
        bus_read(L0, "R3");
        bus_write(C0, 8'h00);
        set_cap(0, 1'b0);
        idle(5);
        bus_read(L0, "R3");
        bus_read(C0, "R3");

        // R4: capture block held between high and low reads
        bus_write(C0, 8'h04);
        bus_read(H0, "R4");
        set_cap(0, 1'b1);
        idle(6);
        bus_read(L0, "R4");
        bus_read(H0, "R4");
        bus_read(L0, "R4");
        set_cap(0, 1'b0);
        idle(3);
        set_cap(0, 1'b1);
        idle(5);
        bus_read(H0, "R4");
        bus_read(L0, "R4");

        // R5: byte layout and unmapped address
        bus_write(C0, 8'h01);
        bus_write(H0, 8'h12);
        bus_write(L0, 8'h34);
        bus_read(H0, "R5");
        bus_read(L0, "R5");
        bus_read(BASE + 3, "R5");
        bus_read(BASE + 12, "R5");

        // R6: match actions without toggle-on-wrap
        bus_write(H0, 8'h00);
        bus_write(L0, 8'd60);
        idle(250);
        chk_pin(0, "R6");
        bus_read(C0, "R6");
        bus_write(C0, 8'h02);
        idle(220);
        chk_pin(0, "R6");
        bus_write(C0, 8'h03);
        idle(220);
        chk_pin(0, "R6");
        bus_write(C0, 8'h01);
        idle(220);
        chk_pin(0, "R6");

        // R7: high write alone suppresses matches
        bus_write(H0, 8'h00);
        idle(420);
        chk_pin(0, "R7");
        bus_write(L0, 8'd60);
        idle(220);
        chk_pin(0, "R7");

        // R8: edge-aligned PWM on channel 1
        bus_write(C1, 8'h21);
        bus_write(H1, 8'h00);
        bus_write(L1, 8'd80);
        idle(450);
        chk_pin(1, "R8");

        // R9: full duty set mid-period, then cleared
        idle(30);
        bus_write(C1, 8'h61);
        idle(450);
        chk_pin(1, "R9");
        bus_write(C1, 8'h21);
        idle(450);
        chk_pin(1, "R9");

        // R11: channel 0 capture while channel 1 runs PWM
        bus_write(C0, 8'h0C);
        set_cap(0, 1'b0);
        idle(5);
        bus_read(H0, "R11");
        bus_read(L0, "R11");
        bus_read(L1, "R11");
        bus_read(C1, "R11");
        idle(300);
        chk_pin(1, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

endmodule